// File: doc/BRIEF.md
# Private Down-Counter Timer with Watchdog

This block holds two 32-bit down-counters on a simple 32-bit register bus: a general timer and a second counter that can act as a watchdog. Each counter has a load value, a live count, a control word and an interrupt status flag. A per-counter 8-bit prescaler divides the clock before it reaches the counter. When a counter reaches zero, it either stops there or reloads for periodic operation. It then raises its status flag, and that flag drives an interrupt if the interrupt is enabled.

The second counter can be switched into watchdog mode. In that mode, reaching zero produces a one-cycle reset pulse and sets a reset-cause flag, and no interrupt is raised. Watchdog mode stays on once set. The only way out is to write two magic words, in a fixed order, to a dedicated disable register. This protects against errant software quietly turning the watchdog off.

The bus is a single-cycle request: a write commits at the clock edge where `req_i` and `we_i` are high. Read data is combinational from the address.

Top module: `ptw_top`

## Requirements
- R1: Register offsets are as follows. Timer: load 0x00, count 0x04, control 0x08, status 0x0C. Watchdog: load 0x20, count 0x24, control 0x28, status 0x2C, reset cause 0x30, disable 0x34. The disable register reads as 0.
- R2: A write to a load register also copies the value into that counter's count register at the same edge.
- R3: The control fields are: bit 0 run, bit 1 auto-reload, bit 2 interrupt enable, bits 15:8 prescale P. Bit 3 is watchdog mode, and exists on the watchdog only. Other bits read as 0. While running, the count falls by one every P+1 clocks.
- R4: Without auto-reload, a counter that reaches zero stays at zero and raises no further events.
- R5: With auto-reload and load value N, the count sequence repeats every (N+1)*(P+1) clocks. The counter reloads N on the tick after it reaches zero.
- R6: A status register's bit 0 is set when its count steps to zero. Writing 1 to that bit clears it. The matching interrupt output equals status AND interrupt enable.
- R7: After reset, all registers read 0 and all outputs are low.
- R8: Writing control bit 3 as 1 enters watchdog mode. Writing it as 0 leaves the mode unchanged.
- R9: Writing 0x12345678 and then 0x87654321 to the disable register leaves watchdog mode. Any other write to the disable register restarts the sequence, and the other control bits are kept.
- R10: In watchdog mode, reaching zero produces a reset pulse exactly one clock long, in the cycle after the count becomes zero. In this mode the status bit is not set and the watchdog interrupt is not raised, whatever the interrupt enable says.
- R11: Each reset pulse sets bit 0 of the reset-cause register. Writing 1 to that bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| tmr_irq_o | output | 1 | Timer interrupt |
| wd_irq_o | output | 1 | Watchdog interrupt (timer mode only) |
| wd_rst_o | output | 1 | One-cycle reset request from watchdog mode |

## Verification
The bench follows the count clock by clock under prescale, and checks the exact phase of the zero event and of the reload. A design that is off by one there would show a period of N or N+2 instead of N+1.

It also checks the following corner cases:
- A stopped counter at zero stays silent. A broken design would keep firing status.
- Writing 0 to the mode bit is ignored. A broken design would let software drop out of watchdog mode.
- Out-of-order and interrupted magic sequences fail to leave watchdog mode.
- The reset pulse is exactly one cycle wide and leaves the interrupt low even when the interrupt enable is set.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam logic [AW-1:0] OFS_LOAD = 8'h00;
  localparam logic [AW-1:0] OFS_CNT  = 8'h04;
  localparam logic [AW-1:0] OFS_CTL  = 8'h08;
  localparam logic [AW-1:0] OFS_STAT = 8'h0C;
  localparam logic [AW-1:0] WD_BASE  = 8'h20;
  localparam logic [AW-1:0] OFS_RSTC = 8'h30;
  localparam logic [AW-1:0] OFS_DIS  = 8'h34;

  localparam int BIT_RUN = 0;
  localparam int BIT_RLD = 1;
  localparam int BIT_IE  = 2;
  localparam int BIT_WD  = 3;
  localparam int PSC_LSB = 8;

  localparam logic [DW-1:0] MAGIC_A = 32'h1234_5678;
  localparam logic [DW-1:0] MAGIC_B = 32'h8765_4321;
endpackage

// File: rtl/ptw_counter.sv
module ptw_counter
  import ptw_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_load_i,
  input  logic          wr_cnt_i,
  input  logic          wr_ctl_i,
  input  logic          wr_clr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          no_stat_i,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] ctl_o,
  output logic          stat_o,
  output logic          zero_o
);
  logic [CW-1:0] load_q, cnt_q;
  logic [PW-1:0] psc_q, pre_q;
  logic run_q, rld_q, ie_q, stat_q;
  logic tick;

  assign tick   = run_q && (pre_q == psc_q);
  assign zero_o = tick && ((cnt_q == CW'(1)) ||
                           (cnt_q == '0 && rld_q && load_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cnt_q  <= '0;
      psc_q  <= '0;
      pre_q  <= '0;
      run_q  <= 1'b0;
      rld_q  <= 1'b0;
      ie_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (!run_q || tick) pre_q <= '0;
      else                pre_q <= pre_q + PW'(1);

      if (wr_ctl_i) begin
        run_q <= wdata_i[BIT_RUN];
        rld_q <= wdata_i[BIT_RLD];
        ie_q  <= wdata_i[BIT_IE];
        psc_q <= wdata_i[PSC_LSB +: PW];
      end

      if (wr_load_i) load_q <= wdata_i[CW-1:0];

      if (wr_load_i || wr_cnt_i) cnt_q <= wdata_i[CW-1:0];
      else if (tick) begin
        if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
        else if (rld_q)  cnt_q <= load_q;
      end

      if (zero_o && !no_stat_i)      stat_q <= 1'b1;
      else if (wr_clr_i && wdata_i[0]) stat_q <= 1'b0;
    end
  end

  always_comb begin
    load_o = DW'(load_q);
    cnt_o  = DW'(cnt_q);
    ctl_o  = '0;
    ctl_o[BIT_RUN] = run_q;
    ctl_o[BIT_RLD] = rld_q;
    ctl_o[BIT_IE]  = ie_q;
    ctl_o[PSC_LSB +: PW] = psc_q;
  end
  assign stat_o = stat_q;

  // R2: load write lands in count
  p_load_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load_i |=> cnt_q == $past(wdata_i[CW-1:0]));
  // R4: one-shot holds at zero
  p_stop_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !rld_q && cnt_q == '0 && !wr_load_i && !wr_cnt_i && !wr_ctl_i)
      |=> cnt_q == '0);
  // R10: status never rises while suppressed
  p_no_stat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_stat_i && !stat_q) |=> !stat_q);
endmodule

// File: rtl/ptw_wd_mode.sv
module ptw_wd_mode
  import ptw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ctl_i,
  input  logic          wr_dis_i,
  input  logic          wr_rstc_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          zero_i,
  output logic          mode_o,
  output logic          rst_o,
  output logic          rstc_o
);
  logic mode_q, armed_q, rst_q, rstc_q;
  logic fire, unlock;

  assign fire   = zero_i && mode_q;
  assign unlock = wr_dis_i && armed_q && (wdata_i == MAGIC_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
      rstc_q  <= 1'b0;
    end else begin
      if (wr_dis_i) armed_q <= (wdata_i == MAGIC_A);

      // sticky: set by control, cleared only by the magic pair
      if (unlock)                            mode_q <= 1'b0;
      else if (wr_ctl_i && wdata_i[BIT_WD])  mode_q <= 1'b1;

      rst_q <= fire;

      if (fire)                          rstc_q <= 1'b1;
      else if (wr_rstc_i && wdata_i[0])  rstc_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign rst_o  = rst_q;
  assign rstc_o = rstc_q;

  // R10: single-cycle pulse
  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  // R11: pulse leaves its cause recorded
  p_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> rstc_q);
  // R8: mode only drops after armed B write
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !(wr_dis_i && armed_q)) |=> mode_q);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          tmr_irq_o,
  output logic          wd_irq_o,
  output logic          wd_rst_o
);
  localparam int NCNT = 2;
  localparam logic [AW-1:0] BASES [NCNT] = '{8'h00, WD_BASE};

  logic          wr;
  logic [DW-1:0] load_v [NCNT];
  logic [DW-1:0] cnt_v  [NCNT];
  logic [DW-1:0] ctl_v  [NCNT];
  logic          stat_v [NCNT];
  logic          zero_v [NCNT];
  logic          wd_mode, wd_rstc;

  assign wr = req_i && we_i;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    ptw_counter #(.CW(CW), .PW(PW)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_load_i (wr && addr_i == BASES[g] + OFS_LOAD),
      .wr_cnt_i  (wr && addr_i == BASES[g] + OFS_CNT),
      .wr_ctl_i  (wr && addr_i == BASES[g] + OFS_CTL),
      .wr_clr_i  (wr && addr_i == BASES[g] + OFS_STAT),
      .wdata_i   (wdata_i),
      .no_stat_i ((g == 1) ? wd_mode : 1'b0),
      .load_o    (load_v[g]),
      .cnt_o     (cnt_v[g]),
      .ctl_o     (ctl_v[g]),
      .stat_o    (stat_v[g]),
      .zero_o    (zero_v[g])
    );
  end

  ptw_wd_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctl_i  (wr && addr_i == WD_BASE + OFS_CTL),
    .wr_dis_i  (wr && addr_i == OFS_DIS),
    .wr_rstc_i (wr && addr_i == OFS_RSTC),
    .wdata_i   (wdata_i),
    .zero_i    (zero_v[1]),
    .mode_o    (wd_mode),
    .rst_o     (wd_rst_o),
    .rstc_o    (wd_rstc)
  );

  assign tmr_irq_o = stat_v[0] && ctl_v[0][BIT_IE];
  assign wd_irq_o  = stat_v[1] && ctl_v[1][BIT_IE] && !wd_mode;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LOAD:           rdata_o = load_v[0];
      OFS_CNT:            rdata_o = cnt_v[0];
      OFS_CTL:            rdata_o = ctl_v[0];
      OFS_STAT:           rdata_o = DW'(stat_v[0]);
      WD_BASE + OFS_LOAD: rdata_o = load_v[1];
      WD_BASE + OFS_CNT:  rdata_o = cnt_v[1];
      WD_BASE + OFS_CTL:  rdata_o = ctl_v[1] | (DW'(wd_mode) << BIT_WD);
      WD_BASE + OFS_STAT: rdata_o = DW'(stat_v[1]);
      OFS_RSTC:           rdata_o = DW'(wd_rstc);
      default:            rdata_o = '0;
    endcase
  end

  // R6: masked interrupt never fires
  p_irq_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_v[0][BIT_IE] |-> !tmr_irq_o);
endmodule

// File: tb/ptw_top_tb_top.sv
module ptw_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tmr_irq, wd_irq, wd_rst;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  ptw_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tmr_irq_o(tmr_irq),
    .wd_irq_o(wd_irq), .wd_rst_o(wd_rst)
  );

  // {is_write, addr, wdata, expected read}
  localparam int NV = 22;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'd5,          32'd0},      // R2
    {1'b0, 8'h04, 32'd0,          32'd5},      // R2
    {1'b0, 8'h00, 32'd0,          32'd5},      // R1
    {1'b1, 8'h04, 32'd9,          32'd0},
    {1'b0, 8'h04, 32'd0,          32'd9},      // R1
    {1'b0, 8'h00, 32'd0,          32'd5},
    {1'b1, 8'h08, 32'hFFFF_FFFE,  32'd0},      // R3
    {1'b0, 8'h08, 32'd0,          32'h0000_FF06},
    {1'b1, 8'h20, 32'd77,         32'd0},
    {1'b0, 8'h24, 32'd0,          32'd77},     // R2
    {1'b1, 8'h28, 32'h8,          32'd0},      // R8
    {1'b0, 8'h28, 32'd0,          32'h8},
    {1'b1, 8'h28, 32'h0,          32'd0},      // R8
    {1'b0, 8'h28, 32'd0,          32'h8},
    {1'b1, 8'h34, 32'h8765_4321,  32'd0},      // R9
    {1'b1, 8'h34, 32'h1234_5678,  32'd0},
    {1'b1, 8'h34, 32'h0000_0000,  32'd0},
    {1'b1, 8'h34, 32'h8765_4321,  32'd0},
    {1'b0, 8'h28, 32'd0,          32'h8},      // R9
    {1'b1, 8'h34, 32'h1234_5678,  32'd0},
    {1'b1, 8'h34, 32'h8765_4321,  32'd0},
    {1'b0, 8'h28, 32'd0,          32'h0}       // R9
  };

  task automatic check(string req_s, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7 reset state
    foreach (BASE_ADDRS[i]) begin
      rd(BASE_ADDRS[i], v);
      check("R7 reg", v, 32'd0);
    end
    check("R7 outs", {29'd0, tmr_irq, wd_irq, wd_rst}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][71:64], v);
        check("R1/R2/R3/R8/R9 vec", v, VEC[i][31:0]);
      end
    end

    // R4, R6 one-shot
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd3);
    wr(8'h08, 32'h5);
    for (int j = 0; j < 6; j++) begin
      rd(8'h04, v);
      check("R4 count", v, (j < 3) ? 32'(3 - j) : 32'd0);
      check("R6 irq", {31'd0, tmr_irq}, (j >= 3) ? 32'd1 : 32'd0);
    end
    wr(8'h0C, 32'h1);
    rd(8'h0C, v);
    check("R6 clear", v, 32'd0);
    repeat (4) rd(8'h0C, v);
    check("R4 no refire", {v[30:0], tmr_irq}, 32'd0);

    // R3, R5 periodic with prescale 1
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd2);
    wr(8'h08, 32'h0000_0107);
    for (int j = 0; j < 14; j++) begin
      rd(8'h04, v);
      check("R5 period", v, 32'(2 - ((j / 2) % 3)));
    end
    wr(8'h08, 32'h0);

    // R6 watchdog in timer mode
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h5);
    rd(8'h2C, v);
    rd(8'h2C, v);
    check("R6 wd stat", v, 32'd1);
    check("R6 wd irq", {31'd0, wd_irq}, 32'd1);
    wr(8'h2C, 32'h1);
    check("R6 wd clr", {31'd0, wd_irq}, 32'd0);

    // R10, R11 watchdog mode
    wr(8'h28, 32'h0);
    wr(8'h20, 32'd2);
    wr(8'h28, 32'hD);
    for (int j = 0; j < 5; j++) begin
      rd(8'h24, v);
      check("R10 pulse", {31'd0, wd_rst}, (j == 2) ? 32'd1 : 32'd0);
      check("R10 no irq", {31'd0, wd_irq}, 32'd0);
    end
    rd(8'h2C, v);
    check("R10 no stat", v, 32'd0);
    rd(8'h30, v);
    check("R11 cause", v, 32'd1);
    wr(8'h30, 32'h1);
    rd(8'h30, v);
    check("R11 clear", v, 32'd0);
    wr(8'h34, 32'h1234_5678);
    wr(8'h34, 32'h8765_4321);
    rd(8'h28, v);
    check("R9 exit keeps bits", v, 32'h5);
    rd(8'h34, v);
    check("R1 dis reads 0", v, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [7:0] BASE_ADDRS [9] =
    '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30};
endmodule